// File: doc/BRIEF.md
# Dispatch Width Throttle with Carry-Over

This block paces a dispatch stage in micro-ops. It keeps a budget of micro-ops that may still leave in the current dispatch cycle. The budget is refilled to the configured dispatch width whenever the surrounding pipeline pulses `new_cycle`. Instructions arrive one at a time on a valid/ready handshake, and each carries its micro-op count as its payload. An instruction is taken if its count fits in what is left of the budget. It is also taken if the budget has not been touched yet in this cycle, however wide the instruction is. When a wide instruction overflows the budget, the excess is held in a carry-over counter, and that counter shrinks the budgets of the cycles that follow.

A fitting instruction also needs three grants from outside the block: reorder-buffer room, free rename mappings and scheduler buffer space. The block checks them in that order. If the budget fits but a grant is missing, it raises a stall, gives the first missing grant as a 2-bit cause code, and increments a saturating counter kept for that cause.

Top module: `dispatch_throttle`

## Requirements
- R1: After reset the budget equals WIDTH, the carry-over is 0 and all three stall counters are 0.
- R2: An instruction whose micro-op count is at most the remaining budget is accepted when all grants are present. The budget then drops by that count at the next clock edge.
- R3: An instruction wider than the remaining budget is accepted while the budget still equals WIDTH. The budget then becomes 0 and the carry-over grows by (count − WIDTH).
- R4: An instruction wider than the remaining budget is refused while the budget is below WIDTH (`in_ready` low). Budget and carry-over keep their values.
- R5: When `new_cycle` is high, `in_ready` is low. At the edge, the budget becomes WIDTH − carry, or 0 if carry ≥ WIDTH. The carry-over drops by WIDTH and saturates at 0.
- R6: `in_ready` requires `rob_ok`, `ren_ok` and `sch_ok` all high. `stall_cause` gives the first missing grant in the order rob, rename, sched, coded 1, 2, 3, and 0 when all grants are present.
- R7: `stall` is high exactly when `in_valid` is high, `new_cycle` is low, the count fits the budget and a grant is missing. The counter for that cause increases by one at the next edge.
- R8: Each stall counter saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_cycle | input | 1 | Starts a new dispatch cycle (refills the budget) |
| in_valid | input | 1 | Instruction offered |
| in_uops | input | UOP_W | Micro-op count of the offered instruction |
| in_ready | output | 1 | Instruction accepted this clock when valid |
| rob_ok | input | 1 | Reorder-buffer room granted |
| ren_ok | input | 1 | Rename mappings granted |
| sch_ok | input | 1 | Scheduler buffer space granted |
| stall | output | 1 | Resource stall event this clock |
| stall_cause | output | 2 | First missing grant: 0 none, 1 rob, 2 rename, 3 sched |
| budget | output | $clog2(WIDTH+1) | Micro-ops left in the current cycle |
| carry | output | UOP_W | Pending carry-over micro-ops |
| stall_cnt_rob | output | CNT_W | Stalls caused by the reorder buffer |
| stall_cnt_ren | output | CNT_W | Stalls caused by rename |
| stall_cnt_sch | output | CNT_W | Stalls caused by the scheduler |

## Verification
`in_ready`, `stall` and `stall_cause` are combinational from the inputs and the registered budget, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these outputs 1 ns later. Budget, carry-over and the stall counters are registered, so they are due one edge later. The bench reads them 1 ns after the rising edge and compares them with a model that it advanced at that same edge.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ROB    = 2'd1,
        CAUSE_RENAME = 2'd2,
        CAUSE_SCHED  = 2'd3
    } stall_cause_e;
endpackage

// File: rtl/grant_checker.sv
module grant_checker
    import throttle_pkg::*;
(
    input  logic         rob_ok,
    input  logic         ren_ok,
    input  logic         sch_ok,
    output logic         all_ok,
    output stall_cause_e cause
);
    // Fixed priority: the first missing grant in check order is reported.
    always_comb begin
        if (!rob_ok)      cause = CAUSE_ROB;
        else if (!ren_ok) cause = CAUSE_RENAME;
        else if (!sch_ok) cause = CAUSE_SCHED;
        else              cause = CAUSE_NONE;
        all_ok = rob_ok && ren_ok && sch_ok;
    end
endmodule

// File: rtl/budget_tracker.sv
module budget_tracker #(
    parameter int WIDTH = 4,
    parameter int UOP_W = 4,
    localparam int BUD_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_cycle,
    input  logic             take,
    input  logic [UOP_W-1:0] uops,
    output logic             fits,
    output logic [BUD_W-1:0] budget,
    output logic [UOP_W-1:0] carry
);
    localparam int CMP_W = ((UOP_W > BUD_W) ? UOP_W : BUD_W) + 1;
    localparam int UMAX  = (1 << UOP_W) - 1;
    localparam int CMAX  = (UMAX > WIDTH) ? (UMAX - WIDTH) : 0;

    typedef struct packed {
        logic [BUD_W-1:0] budget;
        logic [UOP_W-1:0] carry;
    } state_t;

    state_t st_q, st_d;

    logic [CMP_W-1:0] u_x, b_x, c_x, w_x;
    logic             small_fit, full_bud;

    always_comb begin
        u_x       = CMP_W'(uops);
        b_x       = CMP_W'(st_q.budget);
        c_x       = CMP_W'(st_q.carry);
        w_x       = CMP_W'(WIDTH);
        small_fit = (u_x <= b_x);
        full_bud  = (b_x == w_x);
        fits      = small_fit || full_bud;

        st_d = st_q;
        if (new_cycle) begin
            if (c_x >= w_x) begin
                st_d.budget = '0;
                st_d.carry  = UOP_W'(c_x - w_x);
            end else begin
                st_d.budget = BUD_W'(w_x - c_x);
                st_d.carry  = '0;
            end
        end else if (take) begin
            if (small_fit) begin
                st_d.budget = BUD_W'(b_x - u_x);
            end else begin
                st_d.budget = '0;
                st_d.carry  = UOP_W'(c_x + u_x - b_x);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.budget <= BUD_W'(WIDTH);
            st_q.carry  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign budget = st_q.budget;
    assign carry  = st_q.carry;

    AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        b_x <= w_x); // R5
    AST_REFILL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cycle && st_q.carry == '0) |=> (st_q.budget == BUD_W'(WIDTH))); // R5
    AST_OVERSIZE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_cycle && take && !small_fit) |=> (st_q.budget == '0)); // R3
    AST_CARRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        c_x <= CMP_W'(CMAX)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_cycle && !take) |=> (st_q.budget == $past(st_q.budget)
                                   && st_q.carry == $past(st_q.carry))); // R4
endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != '1)) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R7
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '1)); // R8
endmodule

// File: rtl/dispatch_throttle.sv
module dispatch_throttle
    import throttle_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int UOP_W = 4,
    parameter int CNT_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         new_cycle,
    input  logic                         in_valid,
    input  logic [UOP_W-1:0]             in_uops,
    output logic                         in_ready,
    input  logic                         rob_ok,
    input  logic                         ren_ok,
    input  logic                         sch_ok,
    output logic                         stall,
    output logic [1:0]                   stall_cause,
    output logic [$clog2(WIDTH+1)-1:0]   budget,
    output logic [UOP_W-1:0]             carry,
    output logic [CNT_W-1:0]             stall_cnt_rob,
    output logic [CNT_W-1:0]             stall_cnt_ren,
    output logic [CNT_W-1:0]             stall_cnt_sch
);
    localparam int NCAUSE = 3;

    logic         all_ok, fits, take;
    stall_cause_e cause;
    logic [CNT_W-1:0] cnt_w [NCAUSE];

    grant_checker u_grants (
        .rob_ok (rob_ok),
        .ren_ok (ren_ok),
        .sch_ok (sch_ok),
        .all_ok (all_ok),
        .cause  (cause)
    );

    budget_tracker #(.WIDTH(WIDTH), .UOP_W(UOP_W)) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_cycle (new_cycle),
        .take      (take),
        .uops      (in_uops),
        .fits      (fits),
        .budget    (budget),
        .carry     (carry)
    );

    always_comb begin
        in_ready    = !new_cycle && fits && all_ok;
        take        = in_valid && in_ready;
        stall       = in_valid && !new_cycle && fits && !all_ok;
        stall_cause = cause;
    end

    for (genvar i = 0; i < NCAUSE; i++) begin : g_cnt
        stall_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (stall && (stall_cause == 2'(i + 1))),
            .count (cnt_w[i])
        );
    end

    assign stall_cnt_rob = cnt_w[0];
    assign stall_cnt_ren = cnt_w[1];
    assign stall_cnt_sch = cnt_w[2];

    AST_READY_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (rob_ok && ren_ok && sch_ok)); // R6
    AST_TICK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        new_cycle |-> !in_ready); // R5
    AST_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && in_ready)); // R7
    AST_STALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (stall_cause != 2'd0)); // R6
endmodule

// File: tb/tb_dispatch_throttle.sv
`timescale 1ns/1ps
module tb_dispatch_throttle;
    localparam int W     = 4;
    localparam int UW    = 4;
    localparam int CW    = 5;
    localparam int CSAT  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic new_cycle = 1'b0, in_valid = 1'b0;
    logic [UW-1:0] in_uops = '0;
    logic rob_ok = 1'b1, ren_ok = 1'b1, sch_ok = 1'b1;
    logic in_ready, stall;
    logic [1:0] stall_cause;
    logic [$clog2(W+1)-1:0] budget;
    logic [UW-1:0] carry;
    logic [CW-1:0] c_rob, c_ren, c_sch;

    int checks = 0, errors = 0;
    bit done = 0;
    int mb, mc;
    int mcnt [3];

    always #2 clk = ~clk;

    dispatch_throttle #(.WIDTH(W), .UOP_W(UW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .new_cycle(new_cycle), .in_valid(in_valid),
        .in_uops(in_uops), .in_ready(in_ready), .rob_ok(rob_ok), .ren_ok(ren_ok),
        .sch_ok(sch_ok), .stall(stall), .stall_cause(stall_cause),
        .budget(budget), .carry(carry), .stall_cnt_rob(c_rob),
        .stall_cnt_ren(c_ren), .stall_cnt_sch(c_sch)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit f_fits(int u, int b);
        return (u <= b) || (b == W);
    endfunction

    function automatic int f_cause(bit r, bit n, bit s);
        if (!r) return 1;
        if (!n) return 2;
        if (!s) return 3;
        return 0;
    endfunction

    task automatic check_state(string tag);
        check(tag, "budget", int'(budget), mb);
        check(tag, "carry", int'(carry), mc);
        check("R8", "cnt_rob", int'(c_rob), mcnt[0]);
        check("R8", "cnt_ren", int'(c_ren), mcnt[1]);
        check("R8", "cnt_sch", int'(c_sch), mcnt[2]);
    endtask

    task automatic step(bit nc, bit v, int u, bit r, bit n, bit s, string tag);
        bit fit, rdy_e, stl_e;
        int cs;
        @(negedge clk);
        new_cycle = nc; in_valid = v; in_uops = UW'(u);
        rob_ok = r; ren_ok = n; sch_ok = s;
        #1;
        fit   = f_fits(u, mb);
        cs    = f_cause(r, n, s);
        rdy_e = !nc && fit && (cs == 0);
        stl_e = v && !nc && fit && (cs != 0);
        check("R6", "in_ready", int'(in_ready), int'(rdy_e));
        check("R7", "stall", int'(stall), int'(stl_e));
        check("R6", "stall_cause", int'(stall_cause), cs);
        if (nc) begin
            if (mc >= W) begin mb = 0; mc = mc - W; end
            else begin mb = W - mc; mc = 0; end
        end else if (v && rdy_e) begin
            if (u <= mb) mb = mb - u;
            else begin mc = mc + u - mb; mb = 0; end
        end
        if (stl_e && mcnt[cs-1] < CSAT) mcnt[cs-1]++;
        @(posedge clk);
        #1;
        check_state(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        mb = W; mc = 0;
        for (int i = 0; i < 3; i++) mcnt[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: state right after reset
        check("R1", "budget", int'(budget), W);
        check("R1", "carry", int'(carry), 0);
        check("R1", "cnt_rob", int'(c_rob), 0);
        check("R1", "cnt_ren", int'(c_ren), 0);
        check("R1", "cnt_sch", int'(c_sch), 0);

        // R2: small instructions consume the budget
        step(0, 1, 3, 1, 1, 1, "R2");
        // R4: does not fit a partial budget, refused, state kept
        step(0, 1, 2, 1, 1, 1, "R4");
        step(0, 1, 1, 1, 1, 1, "R2");
        step(0, 1, 1, 1, 1, 1, "R4");
        // R5: refill, offered instruction ignored during the tick
        step(1, 1, 1, 1, 1, 1, "R5");
        // R3: oversized accepted at full budget, excess carried
        step(0, 1, 10, 1, 1, 1, "R3");
        step(1, 0, 0, 1, 1, 1, "R5");
        step(0, 1, 1, 1, 1, 1, "R4");
        step(1, 0, 0, 1, 1, 1, "R5");
        step(0, 1, 3, 1, 1, 1, "R4");
        step(1, 0, 0, 1, 1, 1, "R5");
        step(0, 1, 15, 1, 1, 1, "R3");
        for (int k = 0; k < 4; k++) step(1, 0, 0, 1, 1, 1, "R5");
        // R6/R7: grant priority and stall counting
        step(0, 1, 1, 0, 0, 0, "R7");
        step(0, 1, 1, 1, 0, 0, "R7");
        step(0, 1, 1, 1, 1, 0, "R7");
        step(0, 0, 1, 0, 1, 1, "R7");
        step(0, 1, 9, 0, 1, 1, "R7");
        // R8: drive the rob counter into saturation
        for (int k = 0; k < CSAT + 6; k++) step(0, 1, 1, 0, 1, 1, "R8");

        // Constrained random mix
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 10) < 3, ($urandom % 10) < 8, 1 + ($urandom % 15),
                 ($urandom % 10) < 8, ($urandom % 10) < 8, ($urandom % 10) < 8, "R2");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule